// File: doc/BRIEF.md
# Lock elision nesting controller

This block tracks speculative lock elision for a single core. Acquire and release events come in on one event port. Each event carries a lock address, a lock value and the instruction pointer of the instruction that issued it. The controller keeps a bounded nesting depth, an active flag and a restart pointer that it captures on the outermost acquire. It also holds a small table of elided locks, where each entry records an address and a value.

When the last release brings the nesting depth back to zero, the controller asks an external agent to commit the transaction over a valid/ready handshake. Overflow, a bad release, a lock left in the table at depth zero, or a refused commit all lead into one abort path. That path clears all tracking state and, for one cycle, flags the saved restart pointer as the address to resume from. Register checkpointing and discarding of memory updates are outside this block; the abort pulse is their trigger.

Top module: `lock_elide_ctrl`

## Requirements
- R1: An accepted acquire raises the nesting depth by one while the depth is below `NEST_MAX`. An acquire at depth `NEST_MAX` aborts instead.
- R2: An acquire accepted at depth zero sets the active flag and stores its instruction pointer as the restart pointer. Deeper acquires leave the restart pointer unchanged.
- R3: An acquire takes a free table entry and records its address and value there. When the table is full, the acquire is still counted and causes no abort.
- R4: A release at nonzero depth lowers the depth by one. If its address matches a held entry, that entry is freed when the release value equals the recorded value; a different value aborts. A release that matches no entry only changes the depth.
- R5: A release that brings the depth to zero raises `commit_valid` if no table entry is still held. If an entry is still held, the release aborts.
- R6: A commit handshake (`commit_valid` and `commit_ready` both high) with `commit_ok`=1 clears the active flag without an abort. The same handshake with `commit_ok`=0 aborts.
- R7: An abort raises `abort` for exactly one cycle, clears the active flag, sets the depth to zero and frees every table entry. While `abort` is high, `resume_ip` shows the saved restart pointer.
- R8: A release at depth zero raises `legacy` for one cycle and changes neither the depth, the active flag nor the table.
- R9: Once `commit_valid` is raised it stays high until `commit_ready`. While it is high, `ev_ready` is low and any event is ignored.
- R10: Events use `ev_release`=0 for acquire and `ev_release`=1 for release. An event counts only in a cycle where both `ev_valid` and `ev_ready` are high. All results appear on the outputs one clock after the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event present |
| ev_release | input | 1 | 0 = acquire, 1 = release |
| ev_addr | input | ADDR_W | Lock address |
| ev_data | input | DATA_W | Lock value |
| ev_ip | input | IP_W | Instruction pointer of the event |
| ev_ready | output | 1 | Events accepted (low while a commit is pending) |
| commit_valid | output | 1 | Commit request |
| commit_ready | input | 1 | Commit agent answers this cycle |
| commit_ok | input | 1 | Commit result, sampled on the handshake |
| active | output | 1 | Elision in progress |
| nest_level | output | NW | Current nesting depth |
| abort | output | 1 | One-cycle abort pulse |
| resume_ip | output | IP_W | Saved restart pointer |
| legacy | output | 1 | One-cycle pulse for a release at depth zero |

## Verification
The assertions check a set of properties on every cycle:
- the depth never goes above its bound;
- an abort always leaves the depth at zero, the flag clear and the table empty;
- a nonzero depth implies the active flag;
- the restart pointer is captured on the outermost acquire;
- a pending commit holds its request and blocks events;
- a release at depth zero leaves the table untouched.

Some effects only show across a sequence of events, and only the bench's scenarios can show them:
- which table entry a release frees;
- whether entries survive to depth zero and cause an abort;
- whether the table is really empty after an abort;
- how a full table behaves;
- the value carried on `resume_ip` after overflow, a value mismatch or a refused commit.

// File: rtl/lock_elide_ctrl.sv
module lock_elide_ctrl #(
  parameter int NEST_MAX  = 4,
  parameter int BUF_DEPTH = 2,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int IP_W      = 32,
  localparam int NW = $clog2(NEST_MAX + 1),
  localparam int IW = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic              ev_release,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [DATA_W-1:0] ev_data,
  input  logic [IP_W-1:0]   ev_ip,
  output logic              ev_ready,
  output logic              commit_valid,
  input  logic              commit_ready,
  input  logic              commit_ok,
  output logic              active,
  output logic [NW-1:0]     nest_level,
  output logic              abort,
  output logic [IP_W-1:0]   resume_ip,
  output logic              legacy
);

  localparam logic [NW-1:0] NMAX = NW'(NEST_MAX);
  localparam logic [NW-1:0] NONE = '0;

  logic                 active_q, pend_q, abort_q, legacy_q;
  logic [NW-1:0]        nest_q;
  logic [IP_W-1:0]      rip_q;
  logic [BUF_DEPTH-1:0] valid_q;
  logic [ADDR_W-1:0]    addr_q [BUF_DEPTH];
  logic [DATA_W-1:0]    data_q [BUF_DEPTH];

  logic                 acq, rel, free_hit, match_hit, val_ok, left_any, do_abort, commit_hs;
  logic [IW-1:0]        free_idx, match_idx;
  logic [BUF_DEPTH-1:0] free_mask;

  assign ev_ready     = !pend_q;
  assign commit_valid = pend_q;
  assign active       = active_q;
  assign nest_level   = nest_q;
  assign abort        = abort_q;
  assign resume_ip    = rip_q;
  assign legacy       = legacy_q;

  assign acq       = ev_valid && !pend_q && !ev_release;
  assign rel       = ev_valid && !pend_q &&  ev_release;
  assign commit_hs = pend_q && commit_ready;

  always_comb begin
    free_hit  = 1'b0;
    free_idx  = '0;
    match_hit = 1'b0;
    match_idx = '0;
    for (int i = BUF_DEPTH - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        free_hit = 1'b1;
        free_idx = IW'(i);
      end
      if (valid_q[i] && addr_q[i] == ev_addr) begin
        match_hit = 1'b1;
        match_idx = IW'(i);
      end
    end
  end

  assign val_ok = (data_q[match_idx] == ev_data);

  always_comb begin
    free_mask = '0;
    if (match_hit && val_ok) free_mask[match_idx] = 1'b1;
  end

  assign left_any = |(valid_q & ~free_mask);

  assign do_abort = (acq && nest_q == NMAX)
                 || (rel && nest_q != NONE && match_hit && !val_ok)
                 || (rel && nest_q == NW'(1) && left_any)
                 || (commit_hs && !commit_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      abort_q  <= 1'b0;
      legacy_q <= 1'b0;
      nest_q   <= '0;
      rip_q    <= '0;
      valid_q  <= '0;
    end else begin
      abort_q  <= 1'b0;
      legacy_q <= 1'b0;
      if (do_abort) begin
        active_q <= 1'b0;
        pend_q   <= 1'b0;
        abort_q  <= 1'b1;
        nest_q   <= '0;
        valid_q  <= '0;
      end else if (commit_hs) begin
        pend_q   <= 1'b0;
        active_q <= 1'b0;
      end else if (acq) begin
        nest_q <= nest_q + NW'(1);
        if (nest_q == NONE) begin
          active_q <= 1'b1;
          rip_q    <= ev_ip;
        end
        if (free_hit) valid_q[free_idx] <= 1'b1;
      end else if (rel) begin
        if (nest_q == NONE) begin
          legacy_q <= 1'b1;
        end else begin
          nest_q  <= nest_q - NW'(1);
          valid_q <= valid_q & ~free_mask;
          if (nest_q == NW'(1)) pend_q <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !do_abort && !commit_hs && acq && free_hit) begin
      addr_q[free_idx] <= ev_addr;
      data_q[free_idx] <= ev_data;
    end
  end

  AST_NEST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    nest_q <= NMAX); // R1
  AST_FIRST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (acq && nest_q == NONE) |=> (active_q && rip_q == $past(ev_ip))); // R2
  AST_NEST_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (nest_q != NONE) |-> active_q); // R2
  AST_ABORT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |-> (!active_q && nest_q == NONE && valid_q == '0 && !pend_q)); // R7
  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |=> !abort_q); // R7
  AST_COMMIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && !commit_ready) |=> commit_valid); // R9
  AST_PEND_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> !ev_ready); // R9
  AST_LEGACY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rel && nest_q == NONE) |=> (legacy_q && nest_q == NONE && $stable(valid_q))); // R8

endmodule

// File: tb/lock_elide_ctrl_test.sv
module lock_elide_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0, ev_release = 1'b0;
  logic [31:0] ev_addr = '0, ev_data = '0, ev_ip = '0;
  logic        ev_ready, commit_valid, active, abort, legacy;
  logic        commit_ready = 1'b0, commit_ok = 1'b0;
  logic [2:0]  nest_level;
  logic [31:0] resume_ip;
  int checks = 0, errors = 0, cycles = 0;

  lock_elide_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_release(ev_release),
    .ev_addr(ev_addr), .ev_data(ev_data), .ev_ip(ev_ip), .ev_ready(ev_ready),
    .commit_valid(commit_valid), .commit_ready(commit_ready), .commit_ok(commit_ok),
    .active(active), .nest_level(nest_level), .abort(abort),
    .resume_ip(resume_ip), .legacy(legacy)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic ev(input logic r, input logic [31:0] a, input logic [31:0] d, input logic [31:0] ip);
    ev_valid = 1'b1; ev_release = r; ev_addr = a; ev_data = d; ev_ip = ip;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic commit(input logic ok);
    commit_ready = 1'b1; commit_ok = ok;
    @(negedge clk);
    commit_ready = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 reset active", active, 0);
    chk("R10 reset nest", nest_level, 0);
    chk("R9 reset ready", ev_ready, 1);
    chk("R9 reset commit_valid", commit_valid, 0);
    chk("R7 reset abort", abort, 0);
  endtask

  task automatic t_nested_commit;
    ev(0, 32'hA0, 32'h1, 32'h100);
    chk("R1 depth 1", nest_level, 1);
    chk("R2 active", active, 1);
    chk("R2 restart ip", resume_ip, 32'h100);
    ev(0, 32'hB0, 32'h2, 32'h200);
    chk("R1 depth 2", nest_level, 2);
    chk("R2 restart kept", resume_ip, 32'h100);
    ev(1, 32'hB0, 32'h2, 32'h210);
    chk("R4 depth down", nest_level, 1);
    chk("R4 no abort", abort, 0);
    ev(1, 32'hA0, 32'h1, 32'h220);
    chk("R5 commit req", commit_valid, 1);
    chk("R9 ready low", ev_ready, 0);
    ev(0, 32'hC0, 32'h3, 32'h230);
    chk("R9 event ignored", nest_level, 0);
    chk("R9 commit held", commit_valid, 1);
    commit(1);
    chk("R6 active cleared", active, 0);
    chk("R6 no abort", abort, 0);
    chk("R6 req dropped", commit_valid, 0);
  endtask

  task automatic t_commit_fail;
    ev(0, 32'hD0, 32'h4, 32'h300);
    ev(1, 32'hD0, 32'h4, 32'h310);
    commit(0);
    chk("R6 fail aborts", abort, 1);
    chk("R7 resume ip", resume_ip, 32'h300);
    chk("R7 active clear", active, 0);
    @(negedge clk);
    chk("R7 pulse one cycle", abort, 0);
  endtask

  task automatic t_overflow;
    for (int i = 0; i < 4; i++) ev(0, 32'h40 + i, i, 32'h400 + i);
    chk("R1 depth at max", nest_level, 4);
    chk("R1 no abort at max", abort, 0);
    ev(0, 32'h50, 0, 32'h500);
    chk("R1 overflow aborts", abort, 1);
    chk("R7 depth zero", nest_level, 0);
    chk("R7 resume outer ip", resume_ip, 32'h400);
    ev(0, 32'h40, 32'h9, 32'h600);
    ev(1, 32'h40, 32'h9, 32'h610);
    chk("R7 table freed", commit_valid, 1);
    chk("R7 table freed no abort", abort, 0);
    commit(1);
  endtask

  task automatic t_mismatch;
    ev(0, 32'hE0, 32'h5, 32'h700);
    ev(1, 32'hE0, 32'h6, 32'h710);
    chk("R4 value mismatch aborts", abort, 1);
    chk("R4 resume ip", resume_ip, 32'h700);
  endtask

  task automatic t_leftover;
    ev(0, 32'hA1, 32'h1, 32'h800);
    ev(0, 32'hB1, 32'h2, 32'h810);
    ev(1, 32'hC1, 32'h3, 32'h820);
    chk("R4 unmatched release", nest_level, 1);
    chk("R4 unmatched no abort", abort, 0);
    ev(1, 32'hA1, 32'h1, 32'h830);
    chk("R5 leftover aborts", abort, 1);
    chk("R5 no commit", commit_valid, 0);
  endtask

  task automatic t_full;
    ev(0, 32'h11, 32'h1, 32'h900);
    ev(0, 32'h22, 32'h2, 32'h910);
    ev(0, 32'h33, 32'h3, 32'h920);
    chk("R3 full still counts", nest_level, 3);
    chk("R3 full no abort", abort, 0);
    ev(1, 32'h33, 32'h3, 32'h930);
    ev(1, 32'h22, 32'h2, 32'h940);
    ev(1, 32'h11, 32'h1, 32'h950);
    chk("R3 commit after full", commit_valid, 1);
    chk("R3 no abort after full", abort, 0);
    commit(1);
    chk("R3 done", active, 0);
  endtask

  task automatic t_legacy;
    ev(1, 32'h77, 32'h7, 32'hA00);
    chk("R8 legacy pulse", legacy, 1);
    chk("R8 depth kept", nest_level, 0);
    chk("R8 active kept", active, 0);
    chk("R8 no commit", commit_valid, 0);
    ev(0, 32'h77, 32'h7, 32'hA10);
    ev(1, 32'h77, 32'h7, 32'hA20);
    chk("R8 table untouched", commit_valid, 1);
    commit(1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nested_commit();
    t_commit_fail();
    t_overflow();
    t_mismatch();
    t_leftover();
    t_full();
    t_legacy();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule